// File: doc/BRIEF.md
# Output Mismatch Short-Circuit Detector

This block watches a set of half-bridge phases and raises a short-circuit flag when a phase's output level does not match what the gate controller is commanding. Each phase gets a 2-bit drive-state code from the controller and a 1-bit digital sense of its output node. A phase that is told to pull high but reads low, or told to pull low but reads high, is shorted to a supply, to ground or to another phase.

Switching edges take time to settle. For this reason, each phase ignores its own comparison for a programmable number of clock cycles after its drive code changes. Phases that are commanded to high impedance are never compared. The flag only reports the fault. It is the registered OR of the per-phase results and is not latched, so a mismatch that lasts one cycle gives a flag pulse that lasts one cycle. The system controller decides whether to shut the drivers down.

Top module: `sc_mismatch_det`

## Requirements
- R1: While rst_ni is low, sc_flag_o is low and every phase is held blanked. After reset is released, the first comparison of a phase happens BLANK_CYC+1 cycles after release.
- R2: Phase p takes its code from drive_code_i[2p+1:2p]. Code 2'b01 commands the low side on, so the expected sense is 0. Code 2'b10 commands the high side on, so the expected sense is 1. A matching sense never raises the flag.
- R3: Codes 2'b00 (both off) and 2'b11 (both requested, treated as off) put the phase in high impedance. A phase in high impedance is excluded from comparison whatever its sense bit is.
- R4: A phase that is driven, not blanked and whose sense disagrees with its expected level during cycle c drives sc_flag_o high in cycle c+1. Any single phase is enough.
- R5: If a phase's code changes in cycle c, that phase is blanked during cycles c through c+BLANK_CYC. A mismatch that is still present in cycle c+BLANK_CYC+1 is flagged in cycle c+BLANK_CYC+2.
- R6: Blanking is per phase. A code change on one phase does not blank any other phase.
- R7: The flag is not latched and disables nothing. It falls one cycle after the last unblanked mismatch ends, and a mismatch that lasts one cycle yields a flag pulse of one cycle.
- R8: A code change that arrives while a phase is already blanked restarts that phase's full blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drive_code_i | input | 2*N_PHASE | Per-phase drive-state codes, 2 bits per phase |
| out_sense_i | input | N_PHASE | Per-phase digital sense of the output level |
| sc_flag_o | output | 1 | Registered short-circuit flag |

## Verification
The flag is due exactly one cycle after the cycle in which an unblanked mismatch is present. After a code change, a phase stays blind for that cycle plus BLANK_CYC more cycles, so the first possible flag comes BLANK_CYC+2 cycles after the change.

The bench drives one input vector per cycle on the falling edge. For each vector it computes that cycle's expected flag from a per-phase countdown model of the blanking rule and queues it. The monitor pops one entry just after the following rising edge and compares it against sc_flag_o. Every queued vector is therefore checked against the flag value registered from that vector's own cycle.

// File: rtl/sc_det_pkg.sv
package sc_det_pkg;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'b00,
    DRV_LOW  = 2'b01,
    DRV_HIGH = 2'b10,
    DRV_BOTH = 2'b11
  } drv_e;

  function automatic logic drv_active(drv_e c);
    return (c == DRV_LOW) || (c == DRV_HIGH);
  endfunction

  function automatic logic drv_level(drv_e c);
    return c == DRV_HIGH;
  endfunction

endpackage

// File: rtl/sc_blank_timer.sv
module sc_blank_timer
  import sc_det_pkg::*;
#(
  parameter int unsigned BLANK_CYC = 10,
  localparam int unsigned CW = $clog2(BLANK_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  drv_e code_i,
  output logic blank_o
);

  drv_e          prev_q;
  logic [CW-1:0] cnt_q;
  logic          chg;

  assign chg     = (code_i != prev_q);
  assign blank_o = chg | (cnt_q != '0);

  // Reset loads a full window so the phase starts out blind.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= DRV_OFF;
      cnt_q  <= CW'(BLANK_CYC);
    end else begin
      prev_q <= code_i;
      if (chg)                cnt_q <= CW'(BLANK_CYC);
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/sc_phase_cmp.sv
module sc_phase_cmp
  import sc_det_pkg::*;
(
  input  drv_e code_i,
  input  logic sense_i,
  input  logic blank_i,
  output logic mis_o
);

  assign mis_o = !blank_i && drv_active(code_i) && (sense_i != drv_level(code_i));

endmodule

// File: rtl/sc_mismatch_det.sv
module sc_mismatch_det
  import sc_det_pkg::*;
#(
  parameter int unsigned N_PHASE   = 3,
  parameter int unsigned BLANK_CYC = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2*N_PHASE-1:0]   drive_code_i,
  input  logic [N_PHASE-1:0]     out_sense_i,
  output logic                   sc_flag_o
);

  logic [N_PHASE-1:0] mis;
  logic [N_PHASE-1:0] blank;
  logic               sc_q;

  for (genvar g = 0; g < N_PHASE; g++) begin : g_phase
    drv_e code;
    assign code = drv_e'(drive_code_i[2*g +: 2]);

    sc_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .code_i  (code),
      .blank_o (blank[g])
    );

    sc_phase_cmp u_cmp (
      .code_i  (code),
      .sense_i (out_sense_i[g]),
      .blank_i (blank[g]),
      .mis_o   (mis[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sc_q <= 1'b0;
    else         sc_q <= |mis;
  end

  assign sc_flag_o = sc_q;

endmodule

// File: rtl/sc_mismatch_det_chk.sv
module sc_mismatch_det_chk #(
  parameter int unsigned N_PHASE = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [2*N_PHASE-1:0] drive_code_i,
  input logic [N_PHASE-1:0]   out_sense_i,
  input logic                 sc_flag_o
);

  logic [2*N_PHASE-1:0] prev_q;
  logic [N_PHASE-1:0]   raw_mis, hz, chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= drive_code_i;
  end

  for (genvar g = 0; g < N_PHASE; g++) begin : g_obs
    logic [1:0] c;
    assign c          = drive_code_i[2*g +: 2];
    assign hz[g]      = (c == 2'b00) || (c == 2'b11);
    assign chg[g]     = (c != prev_q[2*g +: 2]);
    assign raw_mis[g] = !hz[g] && (out_sense_i[g] != c[1]);
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_rst_low_R1: assert (!sc_flag_o);
  end

  assert_hz_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&hz) |=> !sc_flag_o);

  assert_flag_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_flag_o |-> $past(|raw_mis));

  assert_edge_blank_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&(hz | chg)) |=> !sc_flag_o);

  assert_no_latch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|raw_mis) |=> !sc_flag_o);

endmodule

bind sc_mismatch_det sc_mismatch_det_chk #(.N_PHASE(N_PHASE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .drive_code_i (drive_code_i),
  .out_sense_i  (out_sense_i),
  .sc_flag_o    (sc_flag_o)
);

// File: tb/sim_sc_mismatch_det.sv
module sim_sc_mismatch_det;
  localparam int CLK_PERIOD = 10;
  localparam int NP         = 3;
  localparam int BLANK      = 10;

  localparam logic [1:0] OFF  = 2'b00;
  localparam logic [1:0] LOW  = 2'b01;
  localparam logic [1:0] HIGH = 2'b10;
  localparam logic [1:0] BOTH = 2'b11;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b1;
  logic [2*NP-1:0] code = '0;
  logic [NP-1:0]   sense = '0;
  logic            flag;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sc_mismatch_det #(.N_PHASE(NP), .BLANK_CYC(BLANK)) u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .drive_code_i (code),
    .out_sense_i  (sense),
    .sc_flag_o    (flag)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t      sb_q[$];
  int         total = 0;
  int         bad = 0;
  bit         finished = 0;
  int         m_cnt[NP];
  logic [1:0] m_prev[NP];

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: sc_flag_o=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: one queued expectation per rising edge.
  always @(posedge clk_i) begin
    item_t it;
    #1;
    if (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      check(flag, it.exp, it.tag);
    end
  end

  function automatic logic [2*NP-1:0] pk(input logic [1:0] c2, input logic [1:0] c1,
                                         input logic [1:0] c0);
    return {c2, c1, c0};
  endfunction

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_cnt[p]  = BLANK;
      m_prev[p] = OFF;
    end
  endtask

  // Driver: apply a vector, predict the flag for the next edge, advance the model.
  task automatic step(input logic [2*NP-1:0] c, input logic [NP-1:0] s, input string tag);
    item_t it;
    logic  e;
    e     = 1'b0;
    code  = c;
    sense = s;
    for (int p = 0; p < NP; p++) begin
      logic [1:0] cp;
      bit         blk, act;
      cp  = c[2*p +: 2];
      blk = (cp != m_prev[p]) || (m_cnt[p] != 0);
      act = (cp == LOW) || (cp == HIGH);
      if (!blk && act && (s[p] != (cp == HIGH))) e = 1'b1;
      if (cp != m_prev[p])  m_cnt[p] = BLANK;
      else if (m_cnt[p] > 0) m_cnt[p]--;
      m_prev[p] = cp;
    end
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk_i);
  endtask

  task automatic do_reset(input string tag);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(flag, 1'b0, tag);
    model_reset();
    rst_ni = 1'b1;
  endtask

  initial begin
    model_reset();
    #2;
    code  = pk(OFF, OFF, LOW);
    sense = 3'b001;
    @(negedge clk_i);
    do_reset("R1 flag low in reset");

    repeat (BLANK + 1) step(pk(OFF, OFF, LOW), 3'b001, "R1 R5 blanked after reset");
    repeat (3)         step(pk(OFF, OFF, LOW), 3'b001, "R4 low-side reads high");

    repeat (2) step(pk(OFF, OFF, LOW), 3'b000, "R7 flag falls");
    step(pk(OFF, OFF, LOW), 3'b001, "R7 single-cycle pulse");
    repeat (2) step(pk(OFF, OFF, LOW), 3'b000, "R7 pulse ends");

    repeat (3)         step(pk(OFF, HIGH, LOW), 3'b001, "R6 phase0 live while phase1 blanked");
    repeat (BLANK + 2) step(pk(OFF, HIGH, LOW), 3'b000, "R6 R5 phase1 window then flag");

    repeat (BLANK + 4) step(pk(LOW, HIGH, LOW), 3'b010, "R2 agreement low/high/low");
    repeat (BLANK + 4) step(pk(HIGH, LOW, HIGH), 3'b101, "R2 agreement high/low/high");
    repeat (3)         step(pk(HIGH, LOW, HIGH), 3'b001, "R2 R4 phase2 high reads low");

    repeat (BLANK + 4) step(pk(OFF, BOTH, OFF), 3'b111, "R3 high impedance ignored");
    repeat (3)         step(pk(BOTH, OFF, BOTH), 3'b000, "R3 high impedance ignored");

    for (int k = 0; k < 6; k++) begin
      if (k % 2 == 0) repeat (6) step(pk(OFF, OFF, HIGH), 3'b000, "R8 window restarts");
      else            repeat (6) step(pk(OFF, OFF, LOW), 3'b001, "R8 window restarts");
    end
    repeat (BLANK + 3) step(pk(OFF, OFF, LOW), 3'b001, "R8 R5 flag after final window");

    code  = pk(HIGH, HIGH, HIGH);
    sense = 3'b000;
    do_reset("R1 reset mid-run");
    repeat (BLANK + 3) step(pk(HIGH, HIGH, HIGH), 3'b000, "R1 blanked after second reset");

    @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R1: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule